// File: doc/BRIEF.md
# Instruction Loop Cache Controller

This block sits beside the fetch stage of a DSP core and turns a single loop-start instruction into repeated execution of a short block of code. A loop-start word carries a block length N of 1 to 15 instructions and an iteration count K. It is issued from program memory while the controller is idle. The N instructions after it are fetched from memory once and written into a small local store. Every further pass over the block is served from that store, so program memory is not read again. A second opcode, the replay instruction, runs the block already held in the store K more times without any memory fetch.

The iteration count comes from the instruction itself when its K field is non-zero. When the field is zero, the count comes from a 7-bit loop counter register that software can write. In both cases the counter holds the number of passes still to run and steps down by one at the end of each pass. When the loop finishes it reads zero. Two passes end with one extra cycle: the first pass of a fill loop and the final pass of any loop. In that cycle the core must not advance. Interrupts are masked for as long as a loop is running.

The core consumes one instruction slot per cycle by raising `issue`. On each slot it reads the instruction from memory or from `cacheWord`, as `srcCache` selects.

Top module: `loop_cache`

## Requirements
- R1: A word with bits 15..11 equal to 01110 and a non-zero field N in bits 10..7, issued while no loop runs, starts a fill loop: `loopActive` is high from the next cycle. A word of that form with N = 0 starts nothing.
- R2: A non-zero K in bits 6..0 loads the loop counter with K. K = 0 takes the pass count from the loop counter instead. A loop-start or replay word whose resulting count is 0 starts nothing.
- R3: During the first pass of a fill loop, `srcCache` is 0 and `cacheIdx` steps 0, 1, ..., N-1, one step per issued slot. The memory word on each issued slot is stored at that index.
- R4: On every later pass, `srcCache` is 1 and `cacheWord` equals the word stored at `cacheIdx` during the fill, whatever `memWord` carries.
- R5: After the last slot of a fill pass, and after the last slot of the final pass of any loop, `extraCycle` is high for exactly one cycle and no slot is consumed. With a single pass of a fill loop, only one such cycle occurs.
- R6: The loop counter reads the number of passes still to run, including the current one. It drops by one when the last slot of a pass is issued, and it reads 0 once the loop ends after exactly K passes.
- R7: A word with bits 15..11 equal to 01111 (replay), issued while idle, runs the stored block K times, all passes from the store. Its N field is ignored, and only the final pass has the extra cycle. A replay before any block has been stored starts nothing.
- R8: `irqMask` is high in exactly those cycles in which `loopActive` is high, and both are low after reset.
- R9: A counter write is taken only while no loop runs and no loop starts in that cycle. A write during a loop leaves the counter unchanged.
- R10: While a loop runs and `issue` is low, `cacheIdx`, `srcCache` and the counter hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| issue | input | 1 | Core consumes one instruction slot this cycle |
| memWord | input | 16 | Instruction word from program memory |
| cntWrEn | input | 1 | Write strobe for the loop counter |
| cntWrData | input | 7 | Value written to the loop counter |
| srcCache | output | 1 | 1: take the instruction from `cacheWord`; 0: from memory |
| cacheIdx | output | 4 | Position of the current slot inside the block |
| cacheWord | output | 16 | Stored instruction at `cacheIdx` |
| extraCycle | output | 1 | Extra timing cycle; the core must not advance |
| loopActive | output | 1 | A loop is running |
| irqMask | output | 1 | Interrupts blocked |
| cntRdData | output | 7 | Current loop counter value |

## Verification
A wrong pass count or a counter that steps at the wrong slot shows at `cntRdData` in the same cycle. It then shows as an extra cycle that is missing or out of place on the next slot boundary, and as a loop that ends early or late. A store entry that is written at the wrong index, or not written, first appears on the second pass as a wrong `cacheWord`, which is at least N slots after the fault. The bench therefore runs every loop to its end and compares every active cycle against a cycle-exact expectation. That includes gaps in `issue` and junk on `memWord` during replay.

// File: rtl/loopcache_pkg.sv
`timescale 1ns/1ps
package loopcache_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FILL   = 2'd1,
    ST_REPLAY = 2'd2,
    ST_STALL  = 2'd3
  } lcState_t;

  // strobes from the sequencer to the store
  typedef struct packed {
    logic capture;    // write memWord at the current index
    logic loadLen;    // latch a new block length, drop the old block
    logic markValid;  // last entry of the block written
  } lcStrobe_t;

endpackage

// File: rtl/loopcache_store.sv
`timescale 1ns/1ps
module loopcache_store
  import loopcache_pkg::*;
#(
  parameter int IW    = 16,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  lcStrobe_t        strb,
  input  logic [LEN_W-1:0] idx,
  input  logic [IW-1:0]    wrWord,
  input  logic [LEN_W-1:0] lenIn,
  output logic [IW-1:0]    rdWord,
  output logic [LEN_W-1:0] storedLen,
  output logic             blockValid
);

  localparam int DEPTH = (1 << LEN_W) - 1;

  logic [DEPTH*IW-1:0] flat;

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    logic [IW-1:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        q <= '0;
      end else if (strb.capture && idx == LEN_W'(e)) begin
        q <= wrWord;
      end
    end
    assign flat[e*IW +: IW] = q;
  end

  always_comb begin
    rdWord = '0;
    if (int'(idx) < DEPTH) begin
      rdWord = flat[int'(idx)*IW +: IW];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      storedLen  <= '0;
      blockValid <= 1'b0;
    end else if (strb.loadLen) begin
      storedLen  <= lenIn;
      blockValid <= 1'b0;
    end else if (strb.markValid) begin
      blockValid <= 1'b1;
    end
  end

  AST_CAPTURE_IN_BLOCK: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |-> (idx < storedLen)); // R3

  AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    blockValid |-> (storedLen != '0)); // R1

endmodule

// File: rtl/loopcache_seq.sv
`timescale 1ns/1ps
module loopcache_seq
  import loopcache_pkg::*;
#(
  parameter int IW    = 16,
  parameter int LEN_W = 4,
  parameter int CNT_W = 7,
  parameter logic [IW-LEN_W-CNT_W-1:0] DO_OP   = 5'b01110,
  parameter logic [IW-LEN_W-CNT_W-1:0] REDO_OP = 5'b01111
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             issue,
  input  logic [IW-1:0]    memWord,
  input  logic             cntWrEn,
  input  logic [CNT_W-1:0] cntWrData,
  input  logic [LEN_W-1:0] storedLen,
  input  logic             blockValid,
  output lcStrobe_t        strb,
  output logic [LEN_W-1:0] pos,
  output logic [LEN_W-1:0] lenIn,
  output logic             srcCache,
  output logic             extraCycle,
  output logic             loopActive,
  output logic [CNT_W-1:0] cnt
);

  localparam int OP_W = IW - LEN_W - CNT_W;

  lcState_t         state;
  logic [OP_W-1:0]  opField;
  logic [LEN_W-1:0] nField;
  logic [CNT_W-1:0] kField;
  logic [CNT_W-1:0] effCount;
  logic             startFill;
  logic             startReplay;
  logic             inPass;
  logic             lastSlot;
  logic             needStall;

  assign opField  = memWord[IW-1 -: OP_W];
  assign nField   = memWord[CNT_W +: LEN_W];
  assign kField   = memWord[CNT_W-1:0];
  assign effCount = (kField != '0) ? kField : cnt;

  assign startFill   = (state == ST_IDLE) && issue && (opField == DO_OP)
                       && (nField != '0) && (effCount != '0);
  assign startReplay = (state == ST_IDLE) && issue && (opField == REDO_OP)
                       && blockValid && (effCount != '0);

  assign inPass    = (state == ST_FILL) || (state == ST_REPLAY);
  assign lastSlot  = (pos == storedLen - LEN_W'(1));
  assign needStall = (state == ST_FILL) || (cnt == CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      pos   <= '0;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          pos <= '0;
          if (startFill) begin
            state <= ST_FILL;
            cnt   <= effCount;
          end else if (startReplay) begin
            state <= ST_REPLAY;
            cnt   <= effCount;
          end else if (cntWrEn) begin
            cnt <= cntWrData;
          end
        end
        ST_FILL, ST_REPLAY: begin
          if (issue) begin
            if (lastSlot) begin
              pos   <= '0;
              cnt   <= cnt - CNT_W'(1);
              state <= needStall ? ST_STALL : ST_REPLAY;
            end else begin
              pos <= pos + LEN_W'(1);
            end
          end
        end
        ST_STALL: begin
          state <= (cnt == '0) ? ST_IDLE : ST_REPLAY;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.capture   = (state == ST_FILL) && issue;
    strb.markValid = (state == ST_FILL) && issue && lastSlot;
    strb.loadLen   = startFill;
  end

  assign lenIn      = nField;
  assign srcCache   = (state == ST_REPLAY);
  assign extraCycle = (state == ST_STALL);
  assign loopActive = (state != ST_IDLE);

  AST_SINGLE_EXTRA: assert property (@(posedge clk) disable iff (!rstN)
    extraCycle |=> !extraCycle); // R5

  AST_ZERO_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    $fell(loopActive) |-> (cnt == '0)); // R6

  AST_CNT_NEVER_RISES: assert property (@(posedge clk) disable iff (!rstN)
    (loopActive && $past(loopActive)) |-> (cnt <= $past(cnt))); // R9

  AST_IDX_IN_BLOCK: assert property (@(posedge clk) disable iff (!rstN)
    inPass |-> (pos < storedLen)); // R3

  AST_HOLD_NO_ISSUE: assert property (@(posedge clk) disable iff (!rstN)
    (inPass && !issue) |=> ($stable(pos) && $stable(cnt))); // R10

  AST_REPLAY_HAS_BLOCK: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_REPLAY) |-> blockValid); // R7

endmodule

// File: rtl/loop_cache.sv
`timescale 1ns/1ps
module loop_cache
  import loopcache_pkg::*;
#(
  parameter int IW    = 16,
  parameter int LEN_W = 4,
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             issue,
  input  logic [IW-1:0]    memWord,
  input  logic             cntWrEn,
  input  logic [CNT_W-1:0] cntWrData,
  output logic             srcCache,
  output logic [LEN_W-1:0] cacheIdx,
  output logic [IW-1:0]    cacheWord,
  output logic             extraCycle,
  output logic             loopActive,
  output logic             irqMask,
  output logic [CNT_W-1:0] cntRdData
);

  lcStrobe_t        strb;
  logic [LEN_W-1:0] pos;
  logic [LEN_W-1:0] lenIn;
  logic [LEN_W-1:0] storedLen;
  logic             blockValid;
  logic             active;

  loopcache_seq #(.IW(IW), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_seq (
    .clk        (clk),
    .rstN       (rstN),
    .issue      (issue),
    .memWord    (memWord),
    .cntWrEn    (cntWrEn),
    .cntWrData  (cntWrData),
    .storedLen  (storedLen),
    .blockValid (blockValid),
    .strb       (strb),
    .pos        (pos),
    .lenIn      (lenIn),
    .srcCache   (srcCache),
    .extraCycle (extraCycle),
    .loopActive (active),
    .cnt        (cntRdData)
  );

  loopcache_store #(.IW(IW), .LEN_W(LEN_W)) u_store (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .idx        (pos),
    .wrWord     (memWord),
    .lenIn      (lenIn),
    .rdWord     (cacheWord),
    .storedLen  (storedLen),
    .blockValid (blockValid)
  );

  assign cacheIdx   = pos;
  assign loopActive = active;
  assign irqMask    = active;

endmodule

// File: tb/sim_loop_cache.sv
`timescale 1ns/1ps
module sim_loop_cache;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        issue = 1'b0;
  logic [15:0] memWord = '0;
  logic        cntWrEn = 1'b0;
  logic [6:0]  cntWrData = '0;
  logic        srcCache, extraCycle, loopActive, irqMask;
  logic [3:0]  cacheIdx;
  logic [15:0] cacheWord;
  logic [6:0]  cntRdData;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    bit          src;
    int          idx;
    logic [15:0] word;
    bit          extra;
    int          cnt;
  } exp_t;

  exp_t        q[$];
  exp_t        mon;
  logic [15:0] blk [15];
  int          blkLen = 0;
  int          modelCnt = 0;

  localparam logic [15:0] JUNK = {5'b01110, 4'd3, 7'd5};

  always #2 clk = ~clk;

  loop_cache u0 (
    .clk(clk), .rstN(rstN), .issue(issue), .memWord(memWord),
    .cntWrEn(cntWrEn), .cntWrData(cntWrData), .srcCache(srcCache),
    .cacheIdx(cacheIdx), .cacheWord(cacheWord), .extraCycle(extraCycle),
    .loopActive(loopActive), .irqMask(irqMask), .cntRdData(cntRdData)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(bit iss, logic [15:0] w, bit we, logic [6:0] wd);
    @(posedge clk);
    #1;
    issue = iss; memWord = w; cntWrEn = we; cntWrData = wd;
  endtask

  task automatic pushExp(bit src, int idx, logic [15:0] w, bit extra, int cnt);
    exp_t e;
    e.src = src; e.idx = idx; e.word = w; e.extra = extra; e.cnt = cnt;
    q.push_back(e);
  endtask

  // monitor: compares every cycle against the scoreboard queue
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (loopActive) begin
        check(irqMask == 1'b1, "R8", "irqMask during loop", int'(irqMask), 1);
        if (q.size() == 0) begin
          check(1'b0, "R6", "loop active beyond expected end", 1, 0);
        end else begin
          mon = q.pop_front();
          check(extraCycle == mon.extra, "R5", "extraCycle", int'(extraCycle), int'(mon.extra));
          check(int'(cntRdData) == mon.cnt, "R6", "loop counter", int'(cntRdData), mon.cnt);
          if (!mon.extra) begin
            check(srcCache == mon.src, mon.src ? "R4" : "R3", "srcCache", int'(srcCache), int'(mon.src));
            check(int'(cacheIdx) == mon.idx, "R3", "cacheIdx", int'(cacheIdx), mon.idx);
            if (mon.src)
              check(cacheWord == mon.word, "R4", "cacheWord", int'(cacheWord), int'(mon.word));
          end
        end
      end else begin
        check(irqMask == 1'b0, "R8", "irqMask idle", int'(irqMask), 0);
      end
    end
  end

  // one loop: fill (redo=0) or replay (redo=1); optional issue gap and counter write
  task automatic runLoop(bit redo, int n, int k, int seed, int gapPass, int gapSlot, int wrPass);
    int passes;
    int nEff;
    passes = (k != 0) ? k : modelCnt;
    nEff   = redo ? blkLen : n;
    drive(1'b1, {redo ? 5'b01111 : 5'b01110, 4'(n), 7'(k)}, 1'b0, '0);
    if (!redo) blkLen = n;
    for (int p = 1; p <= passes; p++) begin
      for (int i = 0; i < nEff; i++) begin
        bit fromCache;
        logic [15:0] w;
        fromCache = redo || (p > 1);
        if (p == gapPass && i == gapSlot) begin
          drive(1'b0, JUNK, 1'b0, '0);                        // R10 hold
          pushExp(fromCache, i, blk[i], 1'b0, passes - p + 1);
        end
        if (fromCache) begin
          w = JUNK;
        end else begin
          w = 16'(seed * 4099 + i * 257 + 1);
          blk[i] = w;
        end
        drive(1'b1, w, (p == wrPass && i == 0), 7'h55);      // R9 write ignored
        pushExp(fromCache, i, blk[i], 1'b0, passes - p + 1);
      end
      if ((!redo && p == 1) || p == passes) begin
        drive(1'b1, JUNK, 1'b0, '0);
        pushExp(1'b0, 0, '0, 1'b1, passes - p);
      end
    end
    drive(1'b0, '0, 1'b0, '0);
    @(negedge clk);
    modelCnt = 0;
    check(loopActive == 1'b0, "R6", "loop ended after K passes", int'(loopActive), 0);
    check(int'(cntRdData) == 0, "R6", "counter zero at end", int'(cntRdData), 0);
    check(q.size() == 0, "R6", "expected cycles left over", q.size(), 0);
  endtask

  // a start word that must be ignored
  task automatic noStart(logic [15:0] w, string req);
    drive(1'b1, w, 1'b0, '0);
    drive(1'b0, '0, 1'b0, '0);
    @(negedge clk);
    check(loopActive == 1'b0, req, "start word ignored", int'(loopActive), 0);
    check(int'(cntRdData) == modelCnt, req, "counter untouched", int'(cntRdData), modelCnt);
  endtask

  task automatic writeCnt(int v);
    drive(1'b0, '0, 1'b1, 7'(v));
    drive(1'b0, '0, 1'b0, '0);
    @(negedge clk);
    modelCnt = v;
    check(int'(cntRdData) == v, "R9", "idle counter write", int'(cntRdData), v);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(loopActive == 1'b0, "R8", "reset loopActive", int'(loopActive), 0);
    check(irqMask == 1'b0, "R8", "reset irqMask", int'(irqMask), 0);
    check(extraCycle == 1'b0, "R5", "reset extraCycle", int'(extraCycle), 0);
    check(int'(cntRdData) == 0, "R6", "reset counter", int'(cntRdData), 0);

    noStart({5'b01111, 4'd4, 7'd3}, "R7");   // replay with nothing stored
    noStart({5'b01110, 4'd0, 7'd5}, "R1");   // N = 0
    noStart({5'b01110, 4'd3, 7'd0}, "R2");   // count from counter, counter 0

    writeCnt(4);
    runLoop(1'b0, 3, 0, 1, 0, 0, 0);          // R2 count from counter
    runLoop(1'b0, 4, 3, 2, 2, 1, 2);          // R10 gap, R9 write mid-loop
    runLoop(1'b0, 1, 1, 3, 0, 0, 0);          // R5 single pass, one extra cycle
    runLoop(1'b0, 15, 2, 4, 1, 14, 0);        // full-length block
    runLoop(1'b1, 2, 5, 0, 3, 0, 1);          // R7 replay, N field ignored
    runLoop(1'b1, 0, 1, 0, 0, 0, 0);          // R7 replay single pass
    writeCnt(2);
    runLoop(1'b1, 0, 0, 0, 0, 0, 0);          // R7 replay, count from counter
    runLoop(1'b0, 2, 127, 5, 127, 1, 0);      // R2 largest immediate count
    noStart({5'b01111, 4'd1, 7'd0}, "R2");    // replay with counter 0

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule